// File: doc/BRIEF.md
# Tuning Command Sequencer

This unit starts and supervises one timed command at a time for a receiver's tuning and calibration loops. Software first writes the low byte of a 16-bit target and then the high byte. The high-byte write launches the command chosen by a 2-bit mode field, provided that radio power is on. The target is a frequency in 1 kHz units for AM reception and 10 kHz units for FM. The unit passes the target on to the datapath and does not interpret it.

A programmable cycle count stands in for the loop execution time. During the run the unit reports a busy code. At the end of the run the code changes to an outcome. The outcome is a plain finish, or a converter-limit error when the datapath flagged one during the run, or a forced end when the run was aborted. Aborting happens when either identification register is written or when power drops. A successful tuning run sets a tuned flag and latches a 13-bit current position. The unit raises a sticky interrupt only when the tuned flag falls.

Control and status pins are plain level or strobe signals. There is no data stream and no handshake.

Top module: `tune_cmd_seq`

## Requirements
- R1: A `wr_lo` strobe stores `wr_data` as the low target byte. A `wr_hi` strobe starts a command when all of the following hold: `pwr_on` is 1, `mode` is nonzero, a low byte has been written since the last start, and no command is running. On the next cycle `target` equals {high byte, low byte} and `status` is 3.
- R2: The mode encodings are 0 = none, 1 = measurement, 2 = adjustment and 3 = tuning. A start with mode 0 is ignored. `busy_mode` shows the mode of the running command and shows 0 when the unit is idle.
- R3: The status encodings are 0 = finished without error, 1 = converter limit, 2 = forced end and 3 = busy. A command stays busy for max(`dur_cycles`,1) cycles and then shows 1 if `dp_limit` was high in any busy cycle, otherwise 0.
- R4: A `wr_hi` without a fresh low byte since the last start is ignored.
- R5: A `wr_id` strobe while busy ends the command with status 2 on the next cycle. While the unit is idle, `wr_id` changes nothing.
- R6: A `wr_hi` while busy is ignored. It changes neither `target` nor the run length.
- R7: `pwr_on` low while busy ends the command with status 2. No command starts while `pwr_on` is low.
- R8: A tuning command that ends without limit and without abort sets `tuned` and loads `tune_pos` with the low 13 target bits. Measurement and adjustment commands never set `tuned`.
- R9: `tuned` is 0 on the cycle after any of these: `pwr_on` is low, `lock_lost` is high, or a tuning command starts. Clearing takes precedence over setting.
- R10: `irq` rises on the same edge at which `tuned` falls from 1 to 0, and never when `tuned` rises. `irq` stays high until `irq_clr`, and a new fall takes precedence over the clear.
- R11: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_lo | input | 1 | Low target byte write strobe |
| wr_hi | input | 1 | High target byte write strobe (start) |
| wr_id | input | 1 | Write strobe to an identification register (abort) |
| wr_data | input | 8 | Write data byte |
| mode | input | 2 | Command kind for the next start |
| pwr_on | input | 1 | Radio power enable |
| lock_lost | input | 1 | Loop left its correction range |
| dp_limit | input | 1 | Converter limit reached by datapath |
| dur_cycles | input | 16 | Command duration in cycles (0 acts as 1) |
| irq_clr | input | 1 | Clears the interrupt flag |
| target | output | 16 | Target of the last accepted command |
| busy_mode | output | 2 | Mode of the running command, 0 when idle |
| status | output | 2 | Error/busy code |
| tuned | output | 1 | Tuned flag |
| tune_pos | output | 13 | Current tuned position |
| irq | output | 1 | Loss-of-tuning interrupt flag |

## Verification
The assertions take for granted that at most one of `wr_lo`, `wr_hi` and `wr_id` is high in any cycle, because they share `wr_data` and stand for distinct register writes. The random stimulus enforces this by drawing a single strobe per cycle from one number. Power drops, loss of lock and limit flags are drawn rarely, so that many commands run to completion between them. Durations change only now and then and stay between 0 and 10 cycles, so that every outcome code is reached.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_LIMIT = 2'd1,
    ST_ABORT = 2'd2,
    ST_BUSY  = 2'd3
  } status_e;

  typedef enum logic [1:0] {
    MD_NONE = 2'd0,
    MD_MEAS = 2'd1,
    MD_ADJ  = 2'd2,
    MD_TUNE = 2'd3
  } mode_e;
endpackage

// File: rtl/tcs_target.sv
module tcs_target #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                start,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic                armed,
  output logic [2*BYTE_W-1:0] target
);
  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q   <= '0;
      armed  <= 1'b0;
      target <= '0;
    end else begin
      if (start) begin
        target <= {wr_data, lo_q};
        armed  <= 1'b0;
      end
      if (wr_lo) begin
        lo_q  <= wr_data;
        armed <= 1'b1;
      end
    end
  end

  // a start consumes the armed low byte (R4)
  p_arm_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !wr_lo) |=> !armed);
endmodule

// File: rtl/tcs_timer.sv
module tcs_timer #(
  parameter int DUR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             busy,
  input  logic [DUR_W-1:0] dur_cycles,
  input  logic             dp_limit,
  output logic             done,
  output logic             limit_hit
);
  localparam int CW = DUR_W + 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] dur_eff;
  logic          lim_q;

  always_comb begin
    dur_eff   = (dur_cycles == '0) ? CW'(1) : {1'b0, dur_cycles};
    done      = busy && ((cnt_q + CW'(1)) >= dur_eff);
    limit_hit = lim_q | dp_limit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lim_q <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      lim_q <= 1'b0;
    end else if (busy && !done) begin
      cnt_q <= cnt_q + CW'(1);
      lim_q <= lim_q | dp_limit;
    end
  end

  // every run begins from a cleared count and a clean limit record (R3)
  p_fresh_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == '0 && !lim_q));
endmodule

// File: rtl/tcs_tuned.sv
module tcs_tuned #(
  parameter int POS_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_ok,
  input  logic [POS_W-1:0] pos_in,
  input  logic             clr_start,
  input  logic             pwr_on,
  input  logic             lock_lost,
  input  logic             irq_clr,
  output logic             tuned,
  output logic [POS_W-1:0] tune_pos,
  output logic             irq
);
  logic clear;
  logic tuned_nxt;

  always_comb begin
    clear     = !pwr_on || lock_lost || clr_start;
    tuned_nxt = clear ? 1'b0 : (set_ok ? 1'b1 : tuned);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tuned    <= 1'b0;
      tune_pos <= '0;
      irq      <= 1'b0;
    end else begin
      tuned <= tuned_nxt;
      if (set_ok) tune_pos <= pos_in;
      if (tuned && !tuned_nxt) irq <= 1'b1;
      else if (irq_clr)        irq <= 1'b0;
    end
  end

  p_tuned_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_on || lock_lost) |=> !tuned);

  p_irq_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tuned) |-> irq);

  p_irq_rise_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(tuned));

  p_irq_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);
endmodule

// File: rtl/tune_cmd_seq.sv
module tune_cmd_seq #(
  parameter int BYTE_W = 8,
  parameter int POS_W  = 13,
  parameter int DUR_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic                wr_id,
  input  logic [BYTE_W-1:0]   wr_data,
  input  logic [1:0]          mode,
  input  logic                pwr_on,
  input  logic                lock_lost,
  input  logic                dp_limit,
  input  logic [DUR_W-1:0]    dur_cycles,
  input  logic                irq_clr,
  output logic [2*BYTE_W-1:0] target,
  output logic [1:0]          busy_mode,
  output logic [1:0]          status,
  output logic                tuned,
  output logic [POS_W-1:0]    tune_pos,
  output logic                irq
);
  import tcs_pkg::*;

  localparam int TGT_W = 2 * BYTE_W;

  logic armed, start, busy, kill, done, limit_hit, set_ok, clr_start;
  mode_e   mode_q;
  status_e status_q;

  always_comb begin
    busy      = (mode_q != MD_NONE);
    start     = wr_hi && pwr_on && (mode != 2'(MD_NONE)) && armed && !busy;
    kill      = busy && (!pwr_on || wr_id);
    set_ok    = done && !kill && (mode_q == MD_TUNE) && !limit_hit;
    clr_start = start && (mode == 2'(MD_TUNE));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MD_NONE;
      status_q <= ST_OK;
    end else if (start) begin
      mode_q   <= mode_e'(mode);
      status_q <= ST_BUSY;
    end else if (kill) begin
      mode_q   <= MD_NONE;
      status_q <= ST_ABORT;
    end else if (done) begin
      mode_q   <= MD_NONE;
      status_q <= limit_hit ? ST_LIMIT : ST_OK;
    end
  end

  assign busy_mode = mode_q;
  assign status    = status_q;

  tcs_target #(.BYTE_W(BYTE_W)) i_target (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .start(start),
    .wr_data(wr_data), .armed(armed), .target(target)
  );

  tcs_timer #(.DUR_W(DUR_W)) i_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .dur_cycles(dur_cycles), .dp_limit(dp_limit),
    .done(done), .limit_hit(limit_hit)
  );

  tcs_tuned #(.POS_W(POS_W)) i_tuned (
    .clk(clk), .rst_n(rst_n), .set_ok(set_ok),
    .pos_in(target[POS_W-1:0]), .clr_start(clr_start),
    .pwr_on(pwr_on), .lock_lost(lock_lost), .irq_clr(irq_clr),
    .tuned(tuned), .tune_pos(tune_pos), .irq(irq)
  );

  p_busy_has_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'(ST_BUSY)) |-> (busy_mode != 2'(MD_NONE)));

  p_abort_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mode != 2'(MD_NONE) && wr_id) |=> (status == 2'(ST_ABORT)));

  p_hi_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mode != 2'(MD_NONE) && wr_hi) |=> $stable(target));

  p_power_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mode != 2'(MD_NONE) && !pwr_on) |=> (status == 2'(ST_ABORT)));

  p_no_start_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_mode == 2'(MD_NONE) && !pwr_on) |=> (busy_mode == 2'(MD_NONE)));

  p_tuned_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tuned) |-> ($past(busy_mode) == 2'(MD_TUNE) && status == 2'(ST_OK)));
endmodule

// File: tb/test_tune_cmd_seq.sv
module test_tune_cmd_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, wr_lo, wr_hi, wr_id, pwr_on, lock_lost, dp_limit, irq_clr;
  logic [7:0]  wr_data;
  logic [1:0]  mode;
  logic [15:0] dur_cycles;
  logic [15:0] target;
  logic [1:0]  busy_mode, status;
  logic        tuned, irq;
  logic [12:0] tune_pos;

  tune_cmd_seq i_tune_cmd_seq (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_id(wr_id),
    .wr_data(wr_data), .mode(mode), .pwr_on(pwr_on), .lock_lost(lock_lost),
    .dp_limit(dp_limit), .dur_cycles(dur_cycles), .irq_clr(irq_clr),
    .target(target), .busy_mode(busy_mode), .status(status), .tuned(tuned),
    .tune_pos(tune_pos), .irq(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  // reference model state, built from the requirements
  logic [7:0]  m_lo;
  logic        m_armed, m_lim, m_tuned, m_irq;
  logic [15:0] m_tgt;
  logic [1:0]  m_busy, m_status;
  logic [12:0] m_pos;
  int          m_cnt;

  function automatic int eff_dur(logic [15:0] d);
    return (d == 16'd0) ? 1 : int'(d);
  endfunction

  function automatic logic [1:0] end_code(logic lim);
    return lim ? 2'd1 : 2'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lo = 0; m_armed = 0; m_lim = 0; m_tuned = 0; m_irq = 0;
      m_tgt = 0; m_busy = 0; m_status = 0; m_pos = 0; m_cnt = 0;
    end else begin
      logic old_t, set_t;
      old_t = m_tuned;
      set_t = 0;
      if (m_busy != 0) begin
        if (!pwr_on || wr_id) begin
          m_status = 2'd2; m_busy = 0;
        end else if (m_cnt + 1 >= eff_dur(dur_cycles)) begin
          m_status = end_code(m_lim | dp_limit);
          if (m_busy == 2'd3 && !(m_lim | dp_limit)) begin
            set_t = 1; m_pos = m_tgt[12:0];
          end
          m_busy = 0;
        end else begin
          m_cnt++; m_lim = m_lim | dp_limit;
        end
      end else if (wr_hi && pwr_on && mode != 0 && m_armed) begin
        m_busy = mode; m_status = 2'd3; m_cnt = 0; m_lim = 0;
        m_tgt = {wr_data, m_lo}; m_armed = 0;
        if (mode == 2'd3) m_tuned = 0;
      end
      if (wr_lo) begin m_lo = wr_data; m_armed = 1; end
      if (set_t) m_tuned = 1;
      if (!pwr_on || lock_lost || (old_t && !m_tuned && !set_t)) m_tuned = 0;
      if (old_t && !m_tuned) m_irq = 1;
      else if (irq_clr) m_irq = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R1 target", 32'(target), 32'(m_tgt));
    check("R2 busy_mode", 32'(busy_mode), 32'(m_busy));
    check("R3 status", 32'(status), 32'(m_status));
    check("R9 tuned", 32'(tuned), 32'(m_tuned));
    check("R8 tune_pos", 32'(tune_pos), 32'(m_pos));
    check("R10 irq", 32'(irq), 32'(m_irq));
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) compare_all();
    wr_lo = 0; wr_hi = 0; wr_id = 0; lock_lost = 0; dp_limit = 0; irq_clr = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic w_lo(input logic [7:0] d); wr_data = d; wr_lo = 1; step(); endtask
  task automatic w_hi(input logic [7:0] d); wr_data = d; wr_hi = 1; step(); endtask
  task automatic w_id(); wr_id = 1; step(); endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; wr_lo = 0; wr_hi = 0; wr_id = 0; wr_data = 0; mode = 0;
    pwr_on = 0; lock_lost = 0; dp_limit = 0; dur_cycles = 16'd4; irq_clr = 0;
    idle(3);
    // R11: reset state
    check("R11 status", 32'(status), 0);
    check("R11 tuned", 32'(tuned), 0);
    check("R11 irq", 32'(irq), 0);
    check("R11 target", 32'(target), 0);
    check("R11 busy_mode", 32'(busy_mode), 0);
    rst_n = 1; pwr_on = 1; mode = 2'd3;
    step();

    // R4: high byte without a low byte is ignored
    w_hi(8'h55);
    check("R4 status", 32'(status), 0);
    check("R4 target", 32'(target), 0);

    // R1: start a tuning command
    w_lo(8'h34);
    w_hi(8'h12);
    check("R1 target", 32'(target), 32'h1234);
    check("R1 status", 32'(status), 3);
    check("R2 busy_mode", 32'(busy_mode), 3);
    idle(3);
    check("R3 busy length", 32'(status), 3);
    idle(1);
    check("R3 ok", 32'(status), 0);
    check("R8 tuned", 32'(tuned), 1);
    check("R8 pos", 32'(tune_pos), 32'h1234);

    // R9/R10: loss of lock clears tuned, raises irq
    lock_lost = 1; step();
    check("R9 lock", 32'(tuned), 0);
    check("R10 irq set", 32'(irq), 1);
    idle(2);
    check("R10 irq sticky", 32'(irq), 1);
    irq_clr = 1; step();
    check("R10 irq clr", 32'(irq), 0);

    // R3: measurement with a limit flag
    mode = 2'd1;
    w_lo(8'h01); w_hi(8'h02);
    dp_limit = 1; step();
    idle(3);
    check("R3 limit", 32'(status), 1);
    check("R8 meas no tune", 32'(tuned), 0);

    // R6 then R5: hi write while busy ignored, id write aborts
    mode = 2'd2;
    w_lo(8'hAA); w_hi(8'hBB);
    w_lo(8'h11); w_hi(8'h22);
    check("R6 target", 32'(target), 32'hBBAA);
    check("R6 busy", 32'(status), 3);
    w_id();
    check("R5 abort", 32'(status), 2);
    check("R5 idle mode", 32'(busy_mode), 0);
    w_id();
    check("R5 idle id", 32'(status), 2);

    // R9/R10: new tuning start clears tuned
    mode = 2'd3; dur_cycles = 16'd0;
    w_hi(8'h0F);
    check("R3 dur0 busy", 32'(status), 3);
    step();
    check("R3 dur0 done", 32'(status), 0);
    check("R8 pos mask", 32'(tune_pos), 32'h0F11);
    dur_cycles = 16'd5;
    w_lo(8'h00); w_hi(8'h01);
    check("R9 start clr", 32'(tuned), 0);
    check("R10 start irq", 32'(irq), 1);

    // R7: power drop while busy, no start while off
    pwr_on = 0; step();
    check("R7 abort", 32'(status), 2);
    w_lo(8'h44); w_hi(8'h45);
    check("R7 no start", 32'(busy_mode), 0);
    pwr_on = 1; step();

    // R2: mode none ignored
    mode = 2'd0;
    w_hi(8'h66);
    check("R2 none", 32'(busy_mode), 0);
    check("R2 none target", 32'(target), 32'h0100);

    // constrained random phase
    dur_cycles = 16'd3;
    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      wr_data = 8'($urandom());
      mode = 2'($urandom_range(0, 3));
      wr_lo = (r < 8);
      wr_hi = (r >= 8 && r < 16);
      wr_id = (r >= 16 && r < 19);
      pwr_on = ($urandom_range(0, 59) != 0);
      lock_lost = ($urandom_range(0, 49) == 0);
      dp_limit = ($urandom_range(0, 29) == 0);
      irq_clr = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 99) == 0) dur_cycles = 16'($urandom_range(0, 10));
      step();
    end
    summary();
  end
endmodule